// File: doc/BRIEF.md
# Agree-style hybrid branch direction predictor

This block predicts whether a conditional branch is taken. Three one-bit tables feed the prediction: a per-address table indexed by low branch address bits, a global-history table indexed by the branch address XORed with a global history register, and a chooser table that picks, per branch, which of the two results to use. A table bit does not hold a direction. It says whether the branch will agree with a static hint that the front end supplies with each lookup. The final direction is the hint, inverted when the selected bit says "disagree".

A lookup presents a branch address and hint. One cycle later the block returns the direction, the chosen component, both component bits and the history value used to form the index. The front end keeps these as a checkpoint. When the branch resolves, the checkpoint comes back on the update port together with the actual outcome. The update port then trains the tables and, on a mispredict, repairs the global history. History is updated speculatively with each predicted direction.

Top module: `agree_dir_pred`

## Requirements
- R1: After reset every per-address and history table bit is 1 ("agree"), every chooser bit is 0, and the global history is 0. A first lookup therefore returns the hint as the direction, with pred_sel_gsh = 0 and pred_hist = 0.
- R2: pred_valid is high in exactly the cycle after a cycle with lk_valid high. The other prediction outputs hold the result of that lookup.
- R3: The direction equals the lookup hint when the selected component bit is 1, and is its inverse when that bit is 0. The history component is selected when the chooser bit is 1, the per-address component when it is 0.
- R4: The per-address table is indexed by address bits [BIM_W-1:0]. An update writes its entry with 1 when up_taken equals up_hint, and with 0 otherwise.
- R5: The history table is indexed by address bits [GSH_W-1:0] XOR history. A lookup uses the live history; an update uses up_hist. The update writes the same agree value as R4.
- R6: The chooser is indexed by address bits [SEL_W-1:0]. It is written only when up_bim_agr differs from up_gsh_agr, and then with 1 if up_gsh_agr matches the actual agree value and 0 otherwise.
- R7: In a cycle with pred_valid high, the history shifts left one place and takes pred_taken into bit 0. pred_hist reports the history value that the lookup used.
- R8: An update with up_mispredict high loads the history with {up_hist[GSH_W-2:0], up_taken}. This takes priority over the shift of R7 in the same cycle.
- R9: A lookup and an update that hit the same entry in the same cycle return the entry's value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup branch address |
| lk_hint | input | 1 | Static direction hint, 1 = taken |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | Resolved branch address |
| up_hint | input | 1 | Hint that was used at lookup |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispredict | input | 1 | Final prediction was wrong; repair history |
| up_bim_agr | input | 1 | Per-address bit returned at lookup |
| up_gsh_agr | input | 1 | History-table bit returned at lookup |
| up_hist | input | GSH_W | History returned at lookup |
| pred_valid | output | 1 | Prediction valid |
| pred_taken | output | 1 | Predicted direction |
| pred_sel_gsh | output | 1 | 1 = history component chosen |
| pred_bim_agr | output | 1 | Per-address agree bit |
| pred_gsh_agr | output | 1 | History-table agree bit |
| pred_hist | output | GSH_W | History used for the lookup index |

## Verification
The bench aims at a lookup and an update colliding on one entry in the same cycle. A design that forwards the write would return the new bit instead of the old one. It drives a mispredict repair in the same cycle as a speculative shift: wrong priority would leave one extra predicted bit in the history and misalign every later history index. Chooser training is exercised both with the two component bits equal and with them different. A design that trains the chooser on every update would drift toward one component. Long random runs use a narrow address range, so that aliasing stresses the XOR indexing.

// File: rtl/agree_dir_pred.sv
module agree_dir_pred #(
  parameter int PC_W  = 32,
  parameter int BIM_W = 10,
  parameter int GSH_W = 10,
  parameter int SEL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_hint,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_hint,
  input  logic             up_taken,
  input  logic             up_mispredict,
  input  logic             up_bim_agr,
  input  logic             up_gsh_agr,
  input  logic [GSH_W-1:0] up_hist,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             pred_sel_gsh,
  output logic             pred_bim_agr,
  output logic             pred_gsh_agr,
  output logic [GSH_W-1:0] pred_hist
);
  localparam int BIM_N = 1 << BIM_W;
  localparam int GSH_N = 1 << GSH_W;
  localparam int SEL_N = 1 << SEL_W;

  logic [BIM_N-1:0] bim_t;
  logic [GSH_N-1:0] gsh_t;
  logic [SEL_N-1:0] sel_t;
  logic [GSH_W-1:0] ghist;
  logic             hint_q;

  wire [BIM_W-1:0] lk_bi = lk_pc[BIM_W-1:0];
  wire [GSH_W-1:0] lk_gi = lk_pc[GSH_W-1:0] ^ ghist;
  wire [SEL_W-1:0] lk_si = lk_pc[SEL_W-1:0];
  wire [BIM_W-1:0] up_bi = up_pc[BIM_W-1:0];
  wire [GSH_W-1:0] up_gi = up_pc[GSH_W-1:0] ^ up_hist;
  wire [SEL_W-1:0] up_si = up_pc[SEL_W-1:0];
  wire             up_agree = (up_taken == up_hint);
  wire             sel_agree = pred_sel_gsh ? pred_gsh_agr : pred_bim_agr;

  assign pred_taken = sel_agree ? hint_q : ~hint_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid   <= 1'b0;
      pred_sel_gsh <= 1'b0;
      pred_bim_agr <= 1'b1;
      pred_gsh_agr <= 1'b1;
      pred_hist    <= '0;
      hint_q       <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_sel_gsh <= sel_t[lk_si];
        pred_bim_agr <= bim_t[lk_bi];
        pred_gsh_agr <= gsh_t[lk_gi];
        pred_hist    <= ghist;
        hint_q       <= lk_hint;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bim_t <= '1;
      gsh_t <= '1;
      sel_t <= '0;
    end else if (up_valid) begin
      bim_t[up_bi] <= up_agree;
      gsh_t[up_gi] <= up_agree;
      if (up_bim_agr != up_gsh_agr) sel_t[up_si] <= (up_gsh_agr == up_agree);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ghist <= '0;
    else if (up_valid && up_mispredict) ghist <= {up_hist[GSH_W-2:0], up_taken};
    else if (pred_valid)              ghist <= {ghist[GSH_W-2:0], pred_taken};
  end
endmodule

module agree_dir_pred_chk #(
  parameter int GSH_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hint,
  input logic             up_valid,
  input logic             up_mispredict,
  input logic             up_taken,
  input logic [GSH_W-1:0] up_hist,
  input logic             pred_valid,
  input logic             pred_taken,
  input logic             pred_bim_agr,
  input logic             pred_gsh_agr,
  input logic [GSH_W-1:0] pred_hist,
  input logic [GSH_W-1:0] ghist
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);
  assert_both_agree_keeps_hint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_bim_agr && pred_gsh_agr) |-> (pred_taken == $past(lk_hint)));
  assert_both_disagree_flips_hint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_bim_agr && !pred_gsh_agr) |-> (pred_taken != $past(lk_hint)));
  assert_checkpoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (pred_hist == $past(ghist)));
  assert_spec_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !(up_valid && up_mispredict)) |=>
      (ghist == $past({ghist[GSH_W-2:0], pred_taken})));
  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_mispredict) |=> (ghist == $past({up_hist[GSH_W-2:0], up_taken})));
endmodule

bind agree_dir_pred agree_dir_pred_chk #(.GSH_W(GSH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hint(lk_hint),
  .up_valid(up_valid), .up_mispredict(up_mispredict), .up_taken(up_taken),
  .up_hist(up_hist), .pred_valid(pred_valid), .pred_taken(pred_taken),
  .pred_bim_agr(pred_bim_agr), .pred_gsh_agr(pred_gsh_agr),
  .pred_hist(pred_hist), .ghist(ghist));

// File: tb/agree_dir_pred_bench.sv
module agree_dir_pred_bench;
  localparam int PC_W = 32, BIM_W = 10, GSH_W = 10, SEL_W = 9;
  localparam int BM = (1 << BIM_W) - 1, GM = (1 << GSH_W) - 1, SM = (1 << SEL_W) - 1;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_hint = 0;
  logic [PC_W-1:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_hint = 0, up_taken = 0, up_mispredict = 0, up_bim_agr = 0, up_gsh_agr = 0;
  logic [GSH_W-1:0] up_hist = 0;
  logic pred_valid, pred_taken, pred_sel_gsh, pred_bim_agr, pred_gsh_agr;
  logic [GSH_W-1:0] pred_hist;

  agree_dir_pred #(.PC_W(PC_W), .BIM_W(BIM_W), .GSH_W(GSH_W), .SEL_W(SEL_W)) u_agree_dir_pred (
    .clk, .rst_n, .lk_valid, .lk_pc, .lk_hint, .up_valid, .up_pc, .up_hint, .up_taken,
    .up_mispredict, .up_bim_agr, .up_gsh_agr, .up_hist, .pred_valid, .pred_taken,
    .pred_sel_gsh, .pred_bim_agr, .pred_gsh_agr, .pred_hist);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit mb [0:BM];
  bit mg [0:GM];
  bit mc [0:SM];
  int mh = 0;
  bit e_v = 0, e_t = 0, e_s = 0, e_b = 0, e_g = 0;
  int e_h = 0;

  always @(posedge clk) begin
    bit nb, ng, ns, nt, ag;
    int nh, hh;
    if (!rst_n) begin
      for (int i = 0; i <= BM; i++) mb[i] = 1;
      for (int i = 0; i <= GM; i++) mg[i] = 1;
      for (int i = 0; i <= SM; i++) mc[i] = 0;
      mh = 0; e_v = 0;
    end else begin
      hh = mh;
      if (lk_valid) begin
        nb = mb[lk_pc & BM]; ng = mg[(lk_pc ^ mh) & GM]; ns = mc[lk_pc & SM];
        ag = ns ? ng : nb;
        nt = ag ? lk_hint : !lk_hint;
        nh = mh;
      end
      if (up_valid && up_mispredict) hh = ((int'(up_hist) << 1) | up_taken) & GM;
      else if (e_v) hh = ((mh << 1) | e_t) & GM;
      if (up_valid) begin
        ag = (up_taken == up_hint);
        mb[up_pc & BM] = ag;
        mg[(up_pc ^ up_hist) & GM] = ag;
        if (up_bim_agr != up_gsh_agr) mc[up_pc & SM] = (up_gsh_agr == ag);
      end
      mh = hh;
      e_v = lk_valid;
      if (lk_valid) begin e_b = nb; e_g = ng; e_s = ns; e_t = nt; e_h = nh; end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2", "pred_valid", pred_valid, e_v);
    if (e_v && pred_valid) begin
      chk("R3", "pred_taken", pred_taken, e_t);
      chk("R6", "pred_sel_gsh", pred_sel_gsh, e_s);
      chk("R4", "pred_bim_agr", pred_bim_agr, e_b);
      chk("R5", "pred_gsh_agr", pred_gsh_agr, e_g);
      chk("R7", "pred_hist", pred_hist, e_h);
    end
  end

  task automatic idle();
    lk_valid = 0; up_valid = 0; up_mispredict = 0;
  endtask

  task automatic lookup(int pc, bit hint);
    lk_valid = 1; lk_pc = pc; lk_hint = hint;
  endtask

  task automatic update(int pc, bit hint, bit tk, bit mis, bit ba, bit ga, int h);
    up_valid = 1; up_pc = pc; up_hint = hint; up_taken = tk; up_mispredict = mis;
    up_bim_agr = ba; up_gsh_agr = ga; up_hist = h;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "pred_valid after reset", pred_valid, 0);
    // R1: fresh tables agree, chooser picks per-address, history zero
    lookup(5, 1); @(negedge clk); idle();
    chk("R1", "first taken", pred_taken, 1);
    chk("R1", "first sel", pred_sel_gsh, 0);
    chk("R1", "first hist", pred_hist, 0);
    @(negedge clk);
    // R4 R5 R8: taken=0 with hint=1 writes disagree; history repaired to {0,0}
    update(5, 1, 0, 1, 1, 1, 0); @(negedge clk); idle();
    lookup(5, 1); @(negedge clk); idle();
    chk("R4", "per-address disagree flips", pred_taken, 0);
    chk("R5", "history bit trained", pred_gsh_agr, 0);
    chk("R8", "restored hist", pred_hist, 0);
    @(negedge clk);
    // R6: components differ, history one correct -> chooser = 1
    update(9, 0, 0, 0, 0, 1, 0); @(negedge clk); idle();
    lookup(9, 0); @(negedge clk); idle();
    chk("R6", "chooser to history", pred_sel_gsh, 1);
    @(negedge clk);
    // R6: components equal -> chooser untouched
    update(9, 0, 1, 0, 1, 1, 0); @(negedge clk); idle();
    lookup(9, 0); @(negedge clk); idle();
    chk("R6", "chooser held", pred_sel_gsh, 1);
    @(negedge clk);
    // R9: same-entry lookup and update in one cycle returns old bit
    lookup(300, 1); update(300, 1, 0, 0, 1, 1, 7); @(negedge clk); idle();
    chk("R9", "old per-address bit", pred_bim_agr, 1);
    lookup(300, 1); @(negedge clk); idle();
    chk("R9", "new bit next lookup", pred_bim_agr, 0);
    // R8 over R7: repair and speculative shift in the same cycle
    lookup(12, 1); @(negedge clk); idle();
    update(1, 1, 1, 1, 1, 1, 10'h155); @(negedge clk); idle();
    lookup(12, 1); @(negedge clk); idle();
    chk("R8", "repair wins over shift", pred_hist, 10'h2AB);
    @(negedge clk);
    // random traffic, compared each clock against the model
    for (int n = 0; n < 6000; n++) begin
      idle();
      if ($urandom_range(0, 1)) lookup($urandom_range(0, 63), 1'($urandom));
      if ($urandom_range(0, 2) == 0)
        update($urandom_range(0, 63), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
               1'($urandom), 1'($urandom), $urandom_range(0, GM));
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule